// File: doc/BRIEF.md
# Hash-VM Integer ALU

This block executes the integer operations of a hashing virtual machine. An operation code selects one of twenty-two functions of a 64-bit A operand and a 64-bit B operand, and the block returns a 64-bit C result. The functions cover:

- wrapping add and subtract;
- bitwise AND, OR and XOR;
- four multiply forms that share one multiplier;
- unsigned and signed 64-by-32 division;
- logical and arithmetic shifts, and rotates.

A 32-bit variant of add, subtract and the logic operations works on the low halves of the operands and clears the upper half of C.

Operands enter through a valid/ready input channel, and the result leaves through a valid/ready output channel. The block holds one operation at a time. It raises `in_ready` only when it is empty. A result stays on `out_c`, with `out_valid` high, until the consumer asserts `out_ready`, so back-pressure from the consumer stalls the input side. Every operation except a real division has its result ready one edge after it is accepted. A division runs through an iterative divider that produces two quotient bits per cycle. A division whose divisor is zero, or which would overflow, skips the divider and returns A.

Top module: `hvm_int_alu`

## Requirements
- R1: `in_ready` is high exactly when the block holds no operation (neither computing nor presenting a result). An operation is accepted on a rising edge with `in_valid` and `in_ready` both high. After `out_valid` falls, `in_ready` is high again.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_c` does not change.
- R3: Every operation other than a division that enters the divider raises `out_valid` at the accepting edge.
- R4: Op 0 gives C = A + B and op 1 gives C = A − B, both modulo 2^64.
- R5: The 32-bit ops work on A[31:0] and B[31:0] only, and C[63:32] is zero. They are: op 2 add, op 3 subtract, op 7 AND, op 8 OR, op 9 XOR.
- R6: The 64-bit logic ops are op 4 (A AND B), op 5 (A OR B) and op 6 (A XOR B).
- R7: These ops use the 128-bit product of A and B:
  - op 10 gives the low 64 bits of the unsigned product;
  - op 11 gives the high 64 bits of the unsigned product;
  - op 12 gives the high 64 bits of the signed product.
- R8: These ops give the full 64-bit product of A[31:0] and B[31:0]:
  - op 13 treats both halves as unsigned;
  - op 14 treats both halves as signed.
- R9: Op 15 (unsigned) and op 16 (signed) divide the 64-bit A by the 32-bit B[31:0].
  - The signed quotient rounds toward zero.
  - C[31:0] is the low 32 bits of the quotient, and C[63:32] is zero.
  - With default parameters, `out_valid` rises at the 34th rising edge, counting the accepting edge as the first.
- R10: When B[31:0] is zero, op 15 and op 16 return C = A (all 64 bits) at the accepting edge.
- R11: When op 16 gets A = 0x8000_0000_0000_0000 and B[31:0] = 0xFFFF_FFFF, it returns C = A at the accepting edge.
- R12: The shifts use B[5:0] as the count and ignore B[63:6]:
  - op 17 shifts left;
  - op 18 shifts right, filling with zeros;
  - op 19 shifts right, copying the sign bit.
- R13: The rotates use B[5:0] as the count: op 20 rotates left and op 21 rotates right. A count of 0 returns A.
- R14: During and right after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation presented |
| in_ready | output | 1 | Block can accept an operation |
| in_op | input | 5 | Operation code |
| in_a | input | 64 | Operand A |
| in_b | input | 64 | Operand B |
| out_valid | output | 1 | Result presented |
| out_ready | input | 1 | Consumer takes the result |
| out_c | output | 64 | Result C |

## Verification
The bench targets the edges of the arithmetic, and each case has a distinct failure:

- **Carries across bit 31 in the 32-bit ops.** A design that forgot to clear the upper half would leak a carry or stale bits into C[63:32].
- **All-ones and mixed-sign products.** Picking the wrong half of the product, or the wrong sign extension, changes every upper bit.
- **Quotients wider than 32 bits and negative quotients.** A design that drops the truncation or the sign correction gives a wrong C[31:0].
- **Zero-divisor and minimum-by-minus-one divisions.** If these reached the divider, C would not be A and `out_valid` would come 33 edges late.
- **Shift counts with stray upper bits in B, and rotates by 0 and 63.** These catch a count taken from too many bits, and a wrap-around term that misbehaves at 0.
- **Held results under back-pressure.** These show whether a design overwrites or drops a result while `out_ready` is low.

// File: rtl/hvm_alu_pkg.sv
package hvm_alu_pkg;

  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 5'd0,
    OP_SUB   = 5'd1,
    OP_ADDW  = 5'd2,
    OP_SUBW  = 5'd3,
    OP_AND   = 5'd4,
    OP_OR    = 5'd5,
    OP_XOR   = 5'd6,
    OP_ANDW  = 5'd7,
    OP_ORW   = 5'd8,
    OP_XORW  = 5'd9,
    OP_MULLO = 5'd10,
    OP_MULHU = 5'd11,
    OP_MULHS = 5'd12,
    OP_MULW  = 5'd13,
    OP_MULWS = 5'd14,
    OP_DIVU  = 5'd15,
    OP_DIVS  = 5'd16,
    OP_SLL   = 5'd17,
    OP_SRL   = 5'd18,
    OP_SRA   = 5'd19,
    OP_ROL   = 5'd20,
    OP_ROR   = 5'd21
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_OUT  = 2'd2
  } state_e;

endpackage

// File: rtl/hvm_alu_comb.sv
// Single-cycle datapath: everything except the divider iterations.
module hvm_alu_comb
  import hvm_alu_pkg::*;
#(
  parameter int W = 64
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] c,
  output logic         iter
);

  localparam int HW  = W / 2;
  localparam int SHW = $clog2(W);

  logic [HW-1:0] a_lo, b_lo;
  assign a_lo = a[HW-1:0];
  assign b_lo = b[HW-1:0];

  // One 2W x 2W multiplier; operand conditioning selects the flavour.
  logic [2*W-1:0] ma, mb, prod;
  always_comb begin
    case (op)
      OP_MULHS: begin
        ma = {{W{a[W-1]}}, a};
        mb = {{W{b[W-1]}}, b};
      end
      OP_MULW: begin
        ma = {{(W+HW){1'b0}}, a_lo};
        mb = {{(W+HW){1'b0}}, b_lo};
      end
      OP_MULWS: begin
        ma = {{(W+HW){a_lo[HW-1]}}, a_lo};
        mb = {{(W+HW){b_lo[HW-1]}}, b_lo};
      end
      default: begin
        ma = {{W{1'b0}}, a};
        mb = {{W{1'b0}}, b};
      end
    endcase
  end
  assign prod = ma * mb;

  // Shift count and its complement for the rotate wrap term.
  logic [SHW-1:0] sh;
  logic [SHW:0]   shc;
  assign sh  = b[SHW-1:0];
  assign shc = (SHW+1)'(W) - {1'b0, sh};

  // Division special cases bypass the iterative divider.
  logic is_div, dz, ovf;
  assign is_div = (op == OP_DIVU) || (op == OP_DIVS);
  assign dz     = (b_lo == '0);
  assign ovf    = (op == OP_DIVS) && (a == {1'b1, {(W-1){1'b0}}}) && (b_lo == '1);
  assign iter   = is_div && !dz && !ovf;

  always_comb begin
    case (op)
      OP_ADD:   c = a + b;
      OP_SUB:   c = a - b;
      OP_ADDW:  c = {{HW{1'b0}}, a_lo + b_lo};
      OP_SUBW:  c = {{HW{1'b0}}, a_lo - b_lo};
      OP_AND:   c = a & b;
      OP_OR:    c = a | b;
      OP_XOR:   c = a ^ b;
      OP_ANDW:  c = {{HW{1'b0}}, a_lo & b_lo};
      OP_ORW:   c = {{HW{1'b0}}, a_lo | b_lo};
      OP_XORW:  c = {{HW{1'b0}}, a_lo ^ b_lo};
      OP_MULLO: c = prod[W-1:0];
      OP_MULW:  c = prod[W-1:0];
      OP_MULWS: c = prod[W-1:0];
      OP_MULHU: c = prod[2*W-1:W];
      OP_MULHS: c = prod[2*W-1:W];
      OP_DIVU:  c = a;
      OP_DIVS:  c = a;
      OP_SLL:   c = a << sh;
      OP_SRL:   c = a >> sh;
      OP_SRA:   c = $signed(a) >>> sh;
      OP_ROL:   c = (a << sh) | (a >> shc);
      OP_ROR:   c = (a >> sh) | (a << shc);
      default:  c = '0;
    endcase
  end

endmodule

// File: rtl/hvm_alu_div.sv
// Restoring divider, W-bit dividend by W/2-bit divisor, BPC quotient bits per cycle.
module hvm_alu_div #(
  parameter int W   = 64,
  parameter int BPC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            sgn,
  input  logic [W-1:0]    dividend,
  input  logic [W/2-1:0]  divisor,
  output logic            done,
  output logic [W/2-1:0]  quot
);

  localparam int DW    = W / 2;
  localparam int NSTEP = W / BPC;
  localparam int CW    = (NSTEP > 1) ? $clog2(NSTEP) : 1;

  logic [W-1:0]  sr;
  logic [DW-1:0] rem, dvs;
  logic          neg, busy;
  logic [CW-1:0] cnt;

  // Unrolled restoring stages for one cycle.
  logic [BPC:0][DW-1:0] rc;
  logic [BPC-1:0]       qb;
  assign rc[0] = rem;

  for (genvar k = 0; k < BPC; k++) begin : g_stage
    logic [DW:0] tr, df;
    assign tr = {rc[k], sr[W-1-k]};
    assign df = tr - {1'b0, dvs};
    assign qb[BPC-1-k] = !df[DW];
    assign rc[k+1] = df[DW] ? tr[DW-1:0] : df[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '0;
      rem  <= '0;
      dvs  <= '0;
      neg  <= 1'b0;
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      sr   <= (sgn && dividend[W-1]) ? -dividend : dividend;
      dvs  <= (sgn && divisor[DW-1]) ? -divisor : divisor;
      neg  <= sgn && (dividend[W-1] ^ divisor[DW-1]);
      rem  <= '0;
      cnt  <= '0;
      busy <= 1'b1;
      done <= 1'b0;
    end else if (busy) begin
      sr  <= {sr[W-1-BPC:0], qb};
      rem <= rc[BPC];
      cnt <= cnt + 1'b1;
      if (cnt == CW'(NSTEP - 1)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

  assign quot = neg ? -sr[DW-1:0] : sr[DW-1:0];

endmodule

// File: rtl/hvm_int_alu.sv
module hvm_int_alu
  import hvm_alu_pkg::*;
#(
  parameter int W   = 64,
  parameter int BPC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [OP_W-1:0] in_op,
  input  logic [W-1:0]    in_a,
  input  logic [W-1:0]    in_b,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [W-1:0]    out_c
);

  localparam int HW = W / 2;

  state_e        state;
  logic [W-1:0]  c_q;
  op_e           op;
  logic [W-1:0]  fast_c;
  logic          need_div, accept, div_done;
  logic [HW-1:0] div_q;

  assign op        = op_e'(in_op);
  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_OUT);
  assign out_c     = c_q;
  assign accept    = in_valid && in_ready;

  hvm_alu_comb #(.W(W)) u_comb (
    .op   (op),
    .a    (in_a),
    .b    (in_b),
    .c    (fast_c),
    .iter (need_div)
  );

  hvm_alu_div #(.W(W), .BPC(BPC)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept && need_div),
    .sgn      (op == OP_DIVS),
    .dividend (in_a),
    .divisor  (in_b[HW-1:0]),
    .done     (div_done),
    .quot     (div_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      c_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          if (need_div) begin
            state <= ST_DIV;
          end else begin
            c_q   <= fast_c;
            state <= ST_OUT;
          end
        end
        ST_DIV: if (div_done) begin
          c_q   <= {{HW{1'b0}}, div_q};
          state <= ST_OUT;
        end
        ST_OUT: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hvm_int_alu_chk.sv
module hvm_int_alu_chk
  import hvm_alu_pkg::*;
#(
  parameter int W = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [OP_W-1:0] in_op,
  input logic [W-1:0]    in_a,
  input logic [W-1:0]    in_b,
  input logic            out_valid,
  input logic            out_ready,
  input logic [W-1:0]    out_c
);

  localparam int HW = W / 2;

  logic acc, is_div, dzero, dovf, narrow;
  assign acc    = in_valid && in_ready;
  assign is_div = (in_op == OP_DIVU) || (in_op == OP_DIVS);
  assign dzero  = (in_b[HW-1:0] == '0);
  assign dovf   = (in_op == OP_DIVS) && (in_a == {1'b1, {(W-1){1'b0}}}) && (in_b[HW-1:0] == '1);
  assign narrow = (in_op == OP_ADDW) || (in_op == OP_SUBW) || (in_op == OP_ANDW) ||
                  (in_op == OP_ORW)  || (in_op == OP_XORW);

  AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R1

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_c))); // R2

  AST_FAST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !is_div) |=> out_valid); // R3

  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && narrow) |=> (out_c[W-1:HW] == '0)); // R5

  AST_DIV_ITERATES: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && is_div && !dzero && !dovf) |=> !out_valid); // R9

  AST_DIV_BY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && is_div && dzero) |=> (out_valid && out_c == $past(in_a))); // R10

  AST_DIV_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && dovf) |=> (out_valid && out_c == $past(in_a))); // R11

endmodule

bind hvm_int_alu hvm_int_alu_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_op     (in_op),
  .in_a      (in_a),
  .in_b      (in_b),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_c     (out_c)
);

// File: tb/hvm_int_alu_bench.sv
module hvm_int_alu_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  in_op = '0;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_c;

  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  hvm_int_alu u_hvm_int_alu (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_c(out_c)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(input int op);
    if (op <= 1) return "R4";
    if (op == 2 || op == 3 || (op >= 7 && op <= 9)) return "R5";
    if (op >= 4 && op <= 6) return "R6";
    if (op >= 10 && op <= 12) return "R7";
    if (op == 13 || op == 14) return "R8";
    if (op == 15 || op == 16) return "R9";
    if (op >= 17 && op <= 19) return "R12";
    return "R13";
  endfunction

  function automatic bit special_div(input int op, input logic [63:0] a, input logic [63:0] b);
    if (b[31:0] == 32'd0) return 1'b1;
    return (op == 16) && (a == 64'h8000_0000_0000_0000) && (b[31:0] == 32'hFFFF_FFFF);
  endfunction

  function automatic logic [63:0] model(input int op, input logic [63:0] a, input logic [63:0] b);
    logic [127:0]        pu;
    logic signed [127:0] ps;
    logic [63:0]         r;
    longint              sa, q;
    int                  cnt;
    pu = {64'd0, a} * {64'd0, b};
    ps = $signed(a) * $signed(b);
    cnt = int'(b[5:0]);
    r = a;
    case (op)
      0:  return a + b;
      1:  return a - b;
      2:  return {32'd0, a[31:0] + b[31:0]};
      3:  return {32'd0, a[31:0] - b[31:0]};
      4:  return a & b;
      5:  return a | b;
      6:  return a ^ b;
      7:  return {32'd0, a[31:0] & b[31:0]};
      8:  return {32'd0, a[31:0] | b[31:0]};
      9:  return {32'd0, a[31:0] ^ b[31:0]};
      10: return pu[63:0];
      11: return pu[127:64];
      12: return ps[127:64];
      13: return {32'd0, a[31:0]} * {32'd0, b[31:0]};
      14: return longint'($signed(a[31:0])) * longint'($signed(b[31:0]));
      15: begin
        if (special_div(op, a, b)) return a;
        r = a / {32'd0, b[31:0]};
        return {32'd0, r[31:0]};
      end
      16: begin
        if (special_div(op, a, b)) return a;
        sa = longint'(a);
        q = sa / longint'($signed(b[31:0]));
        r = 64'(q);
        return {32'd0, r[31:0]};
      end
      17: return a << b[5:0];
      18: return a >> b[5:0];
      19: return 64'($signed(a) >>> b[5:0]);
      20: begin
        for (int i = 0; i < cnt; i++) r = {r[62:0], r[63]};
        return r;
      end
      21: begin
        for (int i = 0; i < cnt; i++) r = {r[0], r[63:1]};
        return r;
      end
      default: return 64'd0;
    endcase
  endfunction

  // Number of falling edges after the accepting edge at which out_valid is first seen.
  function automatic int latency(input int op, input logic [63:0] a, input logic [63:0] b);
    if ((op == 15 || op == 16) && !special_div(op, a, b)) return 34;
    return 1;
  endfunction

  task automatic run_op(input int op, input logic [63:0] a, input logic [63:0] b, input int hold);
    logic [63:0] exp;
    int          lat;
    string       lat_req;
    exp = model(op, a, b);
    lat = latency(op, a, b);
    if (op == 15 || op == 16)
      lat_req = (lat == 1) ? ((b[31:0] == 0) ? "R10" : "R11") : "R9";
    else
      lat_req = "R3";
    @(negedge clk);
    chk(in_ready === 1'b1, "R1", {63'd0, in_ready}, 64'd1);
    in_valid  = 1'b1;
    in_op     = 5'(op);
    in_a      = a;
    in_b      = b;
    out_ready = (hold == 0);
    @(negedge clk);
    in_valid = 1'b0;
    for (int n = 1; n < lat; n++) begin
      chk(out_valid === 1'b0, lat_req, {63'd0, out_valid}, 64'd0);
      chk(in_ready === 1'b0, "R1", {63'd0, in_ready}, 64'd0);
      @(negedge clk);
    end
    chk(out_valid === 1'b1, lat_req, {63'd0, out_valid}, 64'd1);
    chk(out_c === exp, (lat_req == "R10" || lat_req == "R11") ? lat_req : req_of(op), out_c, exp);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(out_valid === 1'b1, "R2", {63'd0, out_valid}, 64'd1);
      chk(out_c === exp, "R2", out_c, exp);
      chk(in_ready === 1'b0, "R1", {63'd0, in_ready}, 64'd0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R1", {63'd0, out_valid}, 64'd0);
    chk(in_ready === 1'b1, "R1", {63'd0, in_ready}, 64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL R1 watchdog actual=%h expected=%h", 64'd0, 64'd1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R14: reset state, during and after reset
    chk(out_valid === 1'b0, "R14", {63'd0, out_valid}, 64'd0);
    chk(in_ready === 1'b1, "R14", {63'd0, in_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R14", {63'd0, out_valid}, 64'd0);
    chk(in_ready === 1'b1, "R14", {63'd0, in_ready}, 64'd1);

    // R4
    run_op(0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 0);
    run_op(1, 64'd1, 64'd3, 0);
    // R5
    run_op(2, 64'hABCD_0000_FFFF_FFFF, 64'h1234_0000_0000_0001, 0);
    run_op(3, 64'h0000_0001_0000_0000, 64'd1, 0);
    run_op(7, 64'hFFFF_FFFF_F0F0_F0F0, 64'hFFFF_FFFF_FF00_FF00, 0);
    run_op(8, 64'hFFFF_0000_0000_00F0, 64'h0F00_0000_0000_000F, 0);
    run_op(9, 64'h8000_0000_AAAA_AAAA, 64'h8000_0000_5555_5555, 0);
    // R6
    run_op(4, 64'hF0F0_F0F0_1234_5678, 64'hFF00_FF00_FFFF_0000, 0);
    run_op(5, 64'hF000_0000_0000_000F, 64'h0F00_0000_0000_00F0, 0);
    run_op(6, 64'hDEAD_BEEF_CAFE_F00D, 64'hFFFF_FFFF_0000_0000, 0);
    // R7
    run_op(10, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 0);
    run_op(11, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    run_op(12, 64'hFFFF_FFFF_FFFF_FFFE, 64'h7FFF_FFFF_FFFF_FFFF, 0);
    run_op(12, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 0);
    // R8
    run_op(13, 64'hAAAA_AAAA_FFFF_FFFF, 64'h5555_5555_FFFF_FFFF, 0);
    run_op(14, 64'h0000_0000_FFFF_FFFD, 64'hFFFF_FFFF_0000_0007, 0);
    run_op(14, 64'd0, 64'hFFFF_FFFF_8000_0000, 0);
    // R9
    run_op(15, 64'd1000, 64'hFFFF_FFFF_0000_0007, 0);
    run_op(15, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 0);
    run_op(16, 64'hFFFF_FFFF_FFFF_FF9C, 64'd7, 0);
    run_op(16, 64'd12345678901, 64'h0000_0000_FFFF_FFF0, 0);
    run_op(16, 64'h8000_0000_0000_0000, 64'd1, 0);
    run_op(16, 64'h8000_0000_0000_0000, 64'h0000_0000_8000_0000, 3);
    // R10
    run_op(15, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_0000_0000, 0);
    run_op(16, 64'hFEDC_BA98_7654_3210, 64'd0, 0);
    // R11
    run_op(16, 64'h8000_0000_0000_0000, 64'h0000_0000_FFFF_FFFF, 0);
    // R12
    run_op(17, 64'h8000_0000_0000_0003, 64'hFFFF_FFFF_FFFF_FF41, 0);
    run_op(18, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0080 | 64'd63, 0);
    run_op(19, 64'h8000_0000_0000_0000, 64'd4, 0);
    run_op(19, 64'h7000_0000_0000_0000, 64'd60, 0);
    // R13
    run_op(20, 64'h8000_0000_0000_0001, 64'd1, 0);
    run_op(20, 64'h0123_4567_89AB_CDEF, 64'h40, 0);
    run_op(21, 64'h0123_4567_89AB_CDEF, 64'd63, 0);
    run_op(21, 64'h0000_0000_0000_00F1, 64'hC4, 0);
    // R2: back-pressure on a single-cycle op
    run_op(0, 64'd5, 64'd6, 4);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule